// File: doc/BRIEF.md
# Three-State Power-Mode Sequencer

This block sequences the power state of a processor core between three modes: RUN (core clocked and powered), IDLE (core clock stopped, interrupt watching kept alive) and SLEEP (all on-chip activity in the domain shut down). Software asks for a mode by pulsing a one-cycle request strobe with a 2-bit target code. Every change of mode goes through a timed transition phase. Its length in clock cycles is a parameter chosen per transition kind, so the short hops between RUN and IDLE, the medium entry into SLEEP and the very long wake-up from SLEEP each keep their own latency.

While the core sits in IDLE, any enabled interrupt starts the return to RUN. An optional time-before-shutdown filter moves an IDLE core into SLEEP on its own, but only after the idle period has lasted a programmed number of cycles, so short idle gaps never pay the sleep and wake cost. A power-fault input overrides everything and sends the block toward SLEEP from any state, including the middle of a transition. The request interface has no ready signal. The `busy` output is the only back-pressure: a request presented while `busy` is high is dropped, and software must wait for `busy` to fall and then issue the request again.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block reports RUN (`mode_o` = 00), `core_clk_en` = 1, `dom_pwr_en` = 1 and `busy` = 0.
- R2: `mode_o` reports 00 for RUN, 01 for IDLE and 10 for SLEEP when settled. It reads 11 on exactly the cycles where `busy` is 1.
- R3: A RUN-to-IDLE transition keeps `busy` high for T_RUN_TO_IDLE cycles, and an IDLE-to-RUN transition keeps it high for T_IDLE_TO_RUN cycles. `busy` rises in the cycle after the triggering input is sampled.
- R4: Entering SLEEP from RUN or IDLE keeps `busy` high for T_ENTER_SLEEP cycles. Waking from SLEEP to RUN keeps it high for T_WAKE cycles.
- R5: `core_clk_en` is 1 only while settled in RUN. `dom_pwr_en` is 0 only while settled in SLEEP, and it returns to 1 as soon as a wake transition begins.
- R6: A request (`cmd_valid` = 1) that arrives while `busy` is 1 is ignored. The transition in progress keeps its target and its length.
- R7: While settled in IDLE, an interrupt line that is high and has its enable bit set starts the IDLE-to-RUN transition. An interrupt whose enable bit is 0 has no effect.
- R8: An enabled interrupt seen during any transition is remembered. If that transition lands in IDLE, the IDLE-to-RUN transition starts in the cycle after landing.
- R9: A high `pwr_fault` starts a T_ENTER_SLEEP transition to SLEEP from RUN, from IDLE, or from within a transition not already bound for SLEEP, whatever the state of `busy`. While `pwr_fault` stays high, a wake request is ignored.
- R10: With `idle_limit` = L > 0, a core that stays settled in IDLE with no other event reports 01 for exactly L cycles and then starts the SLEEP entry on its own. With L = 0, automatic shutdown is disabled.
- R11: A request naming the current settled mode, or carrying code 11, is ignored. From SLEEP, only a RUN request (code 00) causes a wake.
- R12: In SLEEP, interrupts have no effect, whether enabled or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle mode request strobe |
| cmd_mode | input | 2 | Requested mode: 00 RUN, 01 IDLE, 10 SLEEP |
| irq | input | NUM_IRQ | Interrupt lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| pwr_fault | input | 1 | Power fault; forces SLEEP |
| idle_limit | input | IDLE_CW | Idle cycles before automatic shutdown; 0 disables it |
| mode_o | output | 2 | Settled mode code, or 11 during a transition |
| core_clk_en | output | 1 | Core clock enable |
| dom_pwr_en | output | 1 | Power-domain enable |
| busy | output | 1 | A transition is in progress |

## Verification
The bench measures every transition length by counting the `busy` cycles one by one. A timer that is off by one, or that shares one count across the asymmetric entries, would show up as a wrong count. It sends requests in the middle of a transition, and a design that sampled requests regardless of `busy` would retarget or restart the timer. It pulses an interrupt during a RUN-to-IDLE transition, which catches a design that drops the interrupt or serves it before landing. It applies a fault mid-transition to check that the sleep timer is reloaded, and holds the fault high to show that wake is blocked. It counts the settled IDLE cycles ahead of an automatic shutdown, which would expose a filter that fires one cycle early or late, or one that fires when the limit is zero.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_XFER  = 2'b11
  } pm_code_e;
endpackage

// File: rtl/pwr_xfer_timer.sv
module pwr_xfer_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          active,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  // load wins over expiry so a fault can restart a running transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt_q  <= len - 1'b1;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign last = active && (cnt_q == '0);

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && cnt_q != '0) |=> (active && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pwr_idle_filter.sv
module pwr_idle_filter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_idle,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = in_idle && (limit != '0) && (cnt_q >= limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!in_idle) cnt_q <= '0;
    else if (!expire)  cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_irq_latch.sv
module pwr_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (clr) pend <= 1'b0;
    else if (set) pend <= 1'b1;
  end

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ       = 4,
  parameter int IDLE_CW       = 16,
  parameter int T_RUN_TO_IDLE = 2000,
  parameter int T_IDLE_TO_RUN = 2000,
  parameter int T_ENTER_SLEEP = 18000,
  parameter int T_WAKE        = 32000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_mode,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               pwr_fault,
  input  logic [IDLE_CW-1:0] idle_limit,
  output logic [1:0]         mode_o,
  output logic               core_clk_en,
  output logic               dom_pwr_en,
  output logic               busy
);
  localparam int T_A   = (T_RUN_TO_IDLE > T_IDLE_TO_RUN) ? T_RUN_TO_IDLE : T_IDLE_TO_RUN;
  localparam int T_B   = (T_ENTER_SLEEP > T_WAKE) ? T_ENTER_SLEEP : T_WAKE;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] LEN_RI = TW'(T_RUN_TO_IDLE);
  localparam logic [TW-1:0] LEN_IR = TW'(T_IDLE_TO_RUN);
  localparam logic [TW-1:0] LEN_SL = TW'(T_ENTER_SLEEP);
  localparam logic [TW-1:0] LEN_WK = TW'(T_WAKE);

  pm_code_e stable_q, target_q;
  logic busy_w, last_w, pend_w, expire_w, irq_hit;
  logic go, heading_sleep;
  logic [TW-1:0] go_len;
  pm_code_e go_tgt;
  logic req_run, req_idle, req_sleep;

  assign irq_hit   = |(irq & irq_en);
  assign req_run   = cmd_valid && (cmd_mode == PM_RUN);
  assign req_idle  = cmd_valid && (cmd_mode == PM_IDLE);
  assign req_sleep = cmd_valid && (cmd_mode == PM_SLEEP);
  assign heading_sleep = busy_w ? (target_q == PM_SLEEP) : (stable_q == PM_SLEEP);

  // priority: fault, then (when settled) interrupt, request, idle expiry
  always_comb begin
    go     = 1'b0;
    go_len = LEN_RI;
    go_tgt = PM_RUN;
    if (pwr_fault && !heading_sleep) begin
      go = 1'b1; go_tgt = PM_SLEEP; go_len = LEN_SL;
    end else if (!busy_w) begin
      case (stable_q)
        PM_RUN: begin
          if (req_idle) begin
            go = 1'b1; go_tgt = PM_IDLE; go_len = LEN_RI;
          end else if (req_sleep) begin
            go = 1'b1; go_tgt = PM_SLEEP; go_len = LEN_SL;
          end
        end
        PM_IDLE: begin
          if (irq_hit || pend_w || req_run) begin
            go = 1'b1; go_tgt = PM_RUN; go_len = LEN_IR;
          end else if (req_sleep || expire_w) begin
            go = 1'b1; go_tgt = PM_SLEEP; go_len = LEN_SL;
          end
        end
        PM_SLEEP: begin
          if (req_run && !pwr_fault) begin
            go = 1'b1; go_tgt = PM_RUN; go_len = LEN_WK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= PM_RUN;
      target_q <= PM_RUN;
    end else if (go) begin
      target_q <= go_tgt;
    end else if (last_w) begin
      stable_q <= target_q;
    end
  end

  pwr_xfer_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go),
    .len    (go_len),
    .active (busy_w),
    .last   (last_w)
  );

  pwr_idle_filter #(.CW(IDLE_CW)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_idle (!busy_w && stable_q == PM_IDLE),
    .limit   (idle_limit),
    .expire  (expire_w)
  );

  pwr_irq_latch u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (busy_w && irq_hit),
    .clr   ((go && go_tgt == PM_RUN) || (last_w && !go && target_q != PM_IDLE)),
    .pend  (pend_w)
  );

  assign busy        = busy_w;
  assign mode_o      = busy_w ? PM_XFER : stable_q;
  assign core_clk_en = !busy_w && (stable_q == PM_RUN);
  assign dom_pwr_en  = busy_w || (stable_q != PM_SLEEP);

  assert_fault_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fault && !busy_w && stable_q == PM_RUN) |=> (busy_w && target_q == PM_SLEEP));
  assert_clk_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(busy_w));
  assert_pwr_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_pwr_en) |-> (busy_w && target_q == PM_RUN));
  assert_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && stable_q == PM_IDLE && irq_hit && !pwr_fault) |=> (busy_w && target_q == PM_RUN));
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !last_w && !pwr_fault) |=> (busy_w && $stable(target_q)));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int NI = 4, CW = 8;
  localparam int L_RI = 4, L_IR = 6, L_SL = 9, L_WK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic [NI-1:0] irq = '0, irq_en = '0;
  logic pwr_fault = 1'b0;
  logic [CW-1:0] idle_limit = '0;
  logic [1:0] mode_o;
  logic core_clk_en, dom_pwr_en, busy;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NI), .IDLE_CW(CW), .T_RUN_TO_IDLE(L_RI),
    .T_IDLE_TO_RUN(L_IR), .T_ENTER_SLEEP(L_SL), .T_WAKE(L_WK)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .irq(irq), .irq_en(irq_en), .pwr_fault(pwr_fault), .idle_limit(idle_limit),
    .mode_o(mode_o), .core_clk_en(core_clk_en), .dom_pwr_en(dom_pwr_en), .busy(busy));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] m);
    cmd_valid = 1'b1; cmd_mode = m;
    step(1);
    cmd_valid = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      step(1);
    end
  endtask

  task automatic t_reset();
    check("R1 mode", mode_o, 0);
    check("R1 clk_en", core_clk_en, 1);
    check("R1 pwr_en", dom_pwr_en, 1);
    check("R1 busy", busy, 0);
  endtask

  task automatic t_run_idle();
    int n;
    send(2'b01);
    check("R2 code during transition", mode_o, 3);
    measure(n);
    check("R3 run to idle length", n, L_RI);
    check("R2 idle code", mode_o, 1);
    check("R5 clk off in idle", core_clk_en, 0);
    check("R5 power kept in idle", dom_pwr_en, 1);
    send(2'b01);
    check("R11 same-mode request ignored", busy, 0);
    send(2'b11);
    check("R11 code 11 ignored", busy, 0);
  endtask

  task automatic t_irq_wake();
    int n;
    irq_en = 4'b0000; irq = 4'b0100;
    step(1);
    check("R7 masked irq ignored", busy, 0);
    irq = '0; irq_en = 4'b0100;
    step(1);
    irq = 4'b0100;
    step(1);
    irq = '0;
    check("R7 enabled irq wakes", busy, 1);
    measure(n);
    check("R3 idle to run length", n, L_IR);
    check("R5 clk back on", core_clk_en, 1);
  endtask

  task automatic t_busy_ignore();
    int n;
    send(2'b01);
    cmd_valid = 1'b1; cmd_mode = 2'b10;
    step(2);
    cmd_valid = 1'b0;
    measure(n);
    check("R6 length unchanged by request", n, L_RI - 2);
    step(1);
    check("R6 target kept", mode_o, 1);
    send(2'b00);
    measure(n);
  endtask

  task automatic t_irq_latch();
    int n;
    send(2'b01);
    irq = 4'b0100;
    step(1);
    irq = '0;
    measure(n);
    check("R8 transition completes first", n, L_RI - 1);
    check("R8 lands in idle", mode_o, 1);
    step(1);
    check("R8 latched irq served", busy, 1);
    measure(n);
    check("R8 back in run", mode_o, 0);
  endtask

  task automatic t_idle_filter();
    int n, k;
    idle_limit = 8'd5;
    send(2'b01);
    measure(n);
    k = 0;
    while (!busy && mode_o == 2'b01 && k < 100) begin
      k++;
      step(1);
    end
    check("R10 idle cycles before shutdown", k, 5);
    measure(n);
    check("R4 sleep entry length", n, L_SL);
    check("R2 sleep code", mode_o, 2);
    check("R5 power off in sleep", dom_pwr_en, 0);
    check("R5 clk off in sleep", core_clk_en, 0);
    idle_limit = '0;
  endtask

  task automatic t_sleep_wake();
    int n;
    irq_en = 4'b1111; irq = 4'b1111;
    step(3);
    irq = '0;
    check("R12 irq ignored in sleep", mode_o, 2);
    send(2'b01);
    check("R11 idle request ignored in sleep", busy, 0);
    send(2'b00);
    check("R5 power on at wake start", dom_pwr_en, 1);
    measure(n);
    check("R4 wake length", n, L_WK);
    check("R4 run after wake", mode_o, 0);
  endtask

  task automatic t_no_filter();
    int n;
    send(2'b01);
    measure(n);
    step(30);
    check("R10 limit zero stays idle", mode_o, 1);
    send(2'b00);
    measure(n);
    check("R3 request to run", mode_o, 0);
  endtask

  task automatic t_fault();
    int n;
    pwr_fault = 1'b1;
    step(1);
    check("R9 fault starts sleep", busy, 1);
    measure(n);
    check("R9 fault entry length", n, L_SL);
    check("R9 in sleep", mode_o, 2);
    send(2'b00);
    check("R9 wake blocked by fault", busy, 0);
    pwr_fault = 1'b0;
    send(2'b00);
    measure(n);
    check("R4 wake after fault", mode_o, 0);
    send(2'b01);
    pwr_fault = 1'b1;
    step(1);
    pwr_fault = 1'b0;
    measure(n);
    check("R9 fault reloads mid-transition", n, L_SL);
    check("R9 sleep after abort", mode_o, 2);
    send(2'b00);
    measure(n);
    send(2'b10);
    measure(n);
    check("R4 requested sleep from run", n, L_SL);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_run_idle();
    t_irq_wake();
    t_busy_ignore();
    t_irq_latch();
    t_idle_filter();
    t_sleep_wake();
    t_no_filter();
    t_fault();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule